// File: doc/BRIEF.md
# Instruction dispatch group former

The block sits behind a decode-stage fetch buffer. Each cycle it looks at the buffer's oldest instructions, up to eight, each marked with a three-bit class code. From them it builds one dispatch group across six slots. Slots 0 to 3 take non-branch work and slots 4 and 5 take branches. The block reports which slots are occupied, which buffer position feeds each slot, and how many buffer entries the group used up. The buffer retires exactly that many entries.

Instructions join strictly in program order. A single branch may sit between non-branch instructions of the same group, but a second branch ends the group. A few classes are pinned to the leading slots. Condition-register work may only use slot 0. A two-slot instruction fills slots 0 and 1. A microcoded instruction fills slots 0 to 3. The group is registered, so outputs show the group built from the inputs seen at the previous rising clock edge. A low ready input freezes the group and reports nothing consumed.

Class codes: 0 simple, 1 condition-register, 2 two-slot, 3 microcoded, 4 branch, and 5 to 7 are handled as simple.

Top module: `dgf_group_former`

## Requirements
- R1: Simple instructions fill non-branch slots 0 to 3 from slot 0 upward in program order, at most four per group. Outputs appear one clock after the inputs are sampled, and `consumed_o` never exceeds 6.
- R2: Branches (code 4) use only slots 4 and 5. The first branch of a group takes slot 4 and the second takes slot 5.
- R3: One branch does not close the group, so non-branch instructions after it still join the same group.
- R4: A second branch is the last member of its group, and nothing after it joins.
- R5: A two-slot instruction (code 2) joins only an empty group. It occupies slots 0 and 1, and both slots carry its index.
- R6: A microcoded instruction (code 3) joins only an empty group and occupies slots 0 to 3 with its index. Later branches may still join.
- R7: A condition-register instruction (code 1) may only take slot 0. If slot 0 is already used, it closes the group.
- R8: The first instruction that cannot be placed closes the group, and no later instruction is placed ahead of it.
- R9: With `ready_i` low at a clock edge, the slot outputs keep their values and `consumed_o` reads 0 after that edge.
- R10: Reset and an input count of 0 both give all slot-valid bits low and `consumed_o` equal to 0.
- R11: Class codes 5 to 7 behave as simple. An input count above 8 is treated as 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_i | input | 1 | Downstream can accept a group this cycle |
| in_cnt_i | input | 4 | Number of valid buffer entries, oldest first |
| in_cls_i | input | 24 | Class code of entry k in bits [3k+2:3k] |
| slot_vld_o | output | 6 | Slot occupied; bits 0-3 non-branch, 4-5 branch |
| slot_idx_o | output | 18 | Buffer index feeding slot s in bits [3s+2:3s] |
| consumed_o | output | 4 | Buffer entries taken by the current group |

## Verification
The bench builds the block with its default parameters: eight buffer entries, four non-branch slots and two branch slots. Every branch closure, every pinning conflict, and the clamp of counts above eight are therefore reachable with short class sequences. Directed groups cover each pinning and closure rule. Thousands of random class mixes with random back-pressure then exercise the interaction of a held group with new buffer contents.

// File: rtl/dgf_pkg.sv
package dgf_pkg;
  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_SIMPLE = 3'd0,
    CLS_CRU    = 3'd1,
    CLS_PAIR   = 3'd2,
    CLS_MICRO  = 3'd3,
    CLS_BRANCH = 3'd4
  } icls_e;
endpackage

// File: rtl/dgf_slot_alloc.sv
module dgf_slot_alloc
  import dgf_pkg::*;
#(
  parameter int N_IN     = 8,
  parameter int NB_SLOTS = 4,
  parameter int BR_SLOTS = 2,
  localparam int NS = NB_SLOTS + BR_SLOTS,
  localparam int IW = $clog2(N_IN),
  localparam int CW = $clog2(N_IN + 1)
) (
  input  logic [CW-1:0]       in_cnt_i,
  input  logic [N_IN*CLS_W-1:0] in_cls_i,
  output logic [NS-1:0]       grp_vld_o,
  output logic [NS*IW-1:0]    grp_idx_o,
  output logic [CW-1:0]       grp_cnt_o
);
  always_comb begin
    int nb;
    int nbr;
    int cnt;
    logic closed;
    logic [CLS_W-1:0] c;
    nb = 0;
    nbr = 0;
    cnt = 0;
    closed = 1'b0;
    grp_vld_o = '0;
    grp_idx_o = '0;
    for (int i = 0; i < N_IN; i++) begin
      c = in_cls_i[i*CLS_W +: CLS_W];
      if (!closed && (i < int'(in_cnt_i))) begin
        case (icls_e'(c))
          CLS_BRANCH: begin
            if (nbr < BR_SLOTS) begin
              grp_vld_o[NB_SLOTS+nbr] = 1'b1;
              grp_idx_o[(NB_SLOTS+nbr)*IW +: IW] = IW'(i);
              nbr = nbr + 1;
              cnt = cnt + 1;
              // the last branch slot ends the group
              if (nbr == BR_SLOTS) closed = 1'b1;
            end else begin
              closed = 1'b1;
            end
          end
          CLS_CRU: begin
            if (nb == 0) begin
              grp_vld_o[0] = 1'b1;
              grp_idx_o[0 +: IW] = IW'(i);
              nb = 1;
              cnt = cnt + 1;
            end else begin
              closed = 1'b1;
            end
          end
          CLS_PAIR: begin
            if (nb == 0 && nbr == 0) begin
              grp_vld_o[1:0] = 2'b11;
              grp_idx_o[0 +: IW] = IW'(i);
              grp_idx_o[IW +: IW] = IW'(i);
              nb = 2;
              cnt = cnt + 1;
            end else begin
              closed = 1'b1;
            end
          end
          CLS_MICRO: begin
            if (nb == 0 && nbr == 0) begin
              for (int k = 0; k < NB_SLOTS; k++) begin
                grp_vld_o[k] = 1'b1;
                grp_idx_o[k*IW +: IW] = IW'(i);
              end
              nb = NB_SLOTS;
              cnt = cnt + 1;
            end else begin
              closed = 1'b1;
            end
          end
          default: begin
            if (nb < NB_SLOTS) begin
              grp_vld_o[nb] = 1'b1;
              grp_idx_o[nb*IW +: IW] = IW'(i);
              nb = nb + 1;
              cnt = cnt + 1;
            end else begin
              closed = 1'b1;
            end
          end
        endcase
      end
    end
    grp_cnt_o = CW'(cnt);
  end
endmodule

// File: rtl/dgf_group_reg.sv
module dgf_group_reg #(
  parameter int NS = 6,
  parameter int IW = 3,
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ready_i,
  input  logic [NS-1:0]    d_vld_i,
  input  logic [NS*IW-1:0] d_idx_i,
  input  logic [CW-1:0]    d_cnt_i,
  output logic [NS-1:0]    q_vld_o,
  output logic [NS*IW-1:0] q_idx_o,
  output logic [CW-1:0]    q_cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_vld_o <= '0;
      q_idx_o <= '0;
      q_cnt_o <= '0;
    end else begin
      if (ready_i) begin
        q_vld_o <= d_vld_i;
        q_idx_o <= d_idx_i;
      end
      // a stalled cycle retires nothing
      q_cnt_o <= ready_i ? d_cnt_i : '0;
    end
  end
endmodule

// File: rtl/dgf_group_former.sv
module dgf_group_former
  import dgf_pkg::*;
#(
  parameter int N_IN     = 8,
  parameter int NB_SLOTS = 4,
  parameter int BR_SLOTS = 2,
  localparam int NS = NB_SLOTS + BR_SLOTS,
  localparam int IW = $clog2(N_IN),
  localparam int CW = $clog2(N_IN + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ready_i,
  input  logic [CW-1:0]         in_cnt_i,
  input  logic [N_IN*CLS_W-1:0] in_cls_i,
  output logic [NS-1:0]         slot_vld_o,
  output logic [NS*IW-1:0]      slot_idx_o,
  output logic [CW-1:0]         consumed_o
);
  logic [NS-1:0]    grp_vld;
  logic [NS*IW-1:0] grp_idx;
  logic [CW-1:0]    grp_cnt;

  dgf_slot_alloc #(
    .N_IN(N_IN), .NB_SLOTS(NB_SLOTS), .BR_SLOTS(BR_SLOTS)
  ) u_alloc (
    .in_cnt_i (in_cnt_i),
    .in_cls_i (in_cls_i),
    .grp_vld_o(grp_vld),
    .grp_idx_o(grp_idx),
    .grp_cnt_o(grp_cnt)
  );

  dgf_group_reg #(.NS(NS), .IW(IW), .CW(CW)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ready_i(ready_i),
    .d_vld_i(grp_vld),
    .d_idx_i(grp_idx),
    .d_cnt_i(grp_cnt),
    .q_vld_o(slot_vld_o),
    .q_idx_o(slot_idx_o),
    .q_cnt_o(consumed_o)
  );
endmodule

// File: rtl/dgf_group_former_chk.sv
module dgf_group_former_chk #(
  parameter int N_IN     = 8,
  parameter int NB_SLOTS = 4,
  parameter int BR_SLOTS = 2,
  localparam int NS = NB_SLOTS + BR_SLOTS,
  localparam int IW = $clog2(N_IN),
  localparam int CW = $clog2(N_IN + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ready_i,
  input logic [NS-1:0]    slot_vld_o,
  input logic [NS*IW-1:0] slot_idx_o,
  input logic [CW-1:0]    consumed_o
);
  logic [NB_SLOTS-1:0] nbv;
  assign nbv = slot_vld_o[NB_SLOTS-1:0];

  p_nb_fill_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((nbv & (nbv + 1'b1)) == '0));

  p_count_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(consumed_o) <= NS));

  p_br_fill_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_vld_o[NS-1] |-> slot_vld_o[NB_SLOTS]);

  p_last_branch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_vld_o[NS-1] && consumed_o != '0) |->
      (slot_idx_o[(NS-1)*IW +: IW] == IW'(consumed_o - 1'b1)));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> ($stable(slot_vld_o) && $stable(slot_idx_o) && consumed_o == '0));

  p_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_vld_o == '0) |-> (consumed_o == '0));
endmodule

bind dgf_group_former dgf_group_former_chk #(
  .N_IN(N_IN), .NB_SLOTS(NB_SLOTS), .BR_SLOTS(BR_SLOTS)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ready_i   (ready_i),
  .slot_vld_o(slot_vld_o),
  .slot_idx_o(slot_idx_o),
  .consumed_o(consumed_o)
);

// File: tb/tb_dgf_group_former.sv
module tb_dgf_group_former;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ready = 1'b1;
  logic [3:0]  in_cnt = '0;
  logic [23:0] in_cls = '0;
  logic [5:0]  slot_vld;
  logic [17:0] slot_idx;
  logic [3:0]  consumed;

  logic [5:0]  exp_vld = '0;
  logic [17:0] exp_idx = '0;
  logic [3:0]  exp_cnt = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dgf_group_former dut (
    .clk_i(clk), .rst_ni(rst_ni), .ready_i(ready),
    .in_cnt_i(in_cnt), .in_cls_i(in_cls),
    .slot_vld_o(slot_vld), .slot_idx_o(slot_idx), .consumed_o(consumed)
  );

  // behavioural reference: walk entries, track slot budgets
  task automatic model(input int n, input int cl[8]);
    int used_nb, used_br, take;
    bit stop;
    exp_vld = '0; exp_idx = '0;
    used_nb = 0; used_br = 0; take = 0; stop = 0;
    if (n > 8) n = 8;
    for (int i = 0; i < n; i++) begin
      if (stop) break;
      if (cl[i] == 4) begin
        if (used_br == 2) stop = 1;
        else begin
          exp_vld[4+used_br] = 1'b1;
          exp_idx[(4+used_br)*3 +: 3] = 3'(i);
          used_br++; take++;
          if (used_br == 2) stop = 1;
        end
      end else if (cl[i] == 1) begin
        if (used_nb != 0) stop = 1;
        else begin exp_vld[0] = 1'b1; exp_idx[2:0] = 3'(i); used_nb = 1; take++; end
      end else if (cl[i] == 2) begin
        if (used_nb != 0 || used_br != 0) stop = 1;
        else begin
          exp_vld[1:0] = 2'b11; exp_idx[5:0] = {3'(i), 3'(i)};
          used_nb = 2; take++;
        end
      end else if (cl[i] == 3) begin
        if (used_nb != 0 || used_br != 0) stop = 1;
        else begin
          exp_vld[3:0] = 4'hf;
          exp_idx[11:0] = {4{3'(i)}};
          used_nb = 4; take++;
        end
      end else begin
        if (used_nb == 4) stop = 1;
        else begin
          exp_vld[used_nb] = 1'b1;
          exp_idx[used_nb*3 +: 3] = 3'(i);
          used_nb++; take++;
        end
      end
    end
    exp_cnt = 4'(take);
  endtask

  task automatic check(input string tag);
    n_chk++;
    if (slot_vld !== exp_vld || consumed !== exp_cnt ||
        ((slot_idx & {{3{exp_vld[5]}}, {3{exp_vld[4]}}, {3{exp_vld[3]}},
                      {3{exp_vld[2]}}, {3{exp_vld[1]}}, {3{exp_vld[0]}}})
          !== exp_idx)) begin
      n_bad++;
      $display("FAIL %s: actual vld=%b idx=%h cnt=%0d expected vld=%b idx=%h cnt=%0d",
               tag, slot_vld, slot_idx, consumed, exp_vld, exp_idx, exp_cnt);
    end
  endtask

  // called at a negedge: drive, then check after the next edge
  task automatic drive(input int n, input int cl[8], input bit rdy, input string tag);
    in_cnt = 4'(n);
    for (int i = 0; i < 8; i++) in_cls[i*3 +: 3] = 3'(cl[i]);
    ready = rdy;
    if (rdy) model(n, cl);
    else exp_cnt = '0;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset state");
    rst_ni = 1'b1;
    drive(0, '{0,0,0,0,0,0,0,0}, 1, "R10 empty input");
    drive(6, '{0,0,0,0,0,0,0,0}, 1, "R1 six simple");
    drive(5, '{0,0,0,0,0,4,0,0}, 1, "R8 branch behind full group");
    drive(4, '{0,4,0,0,0,0,0,0}, 1, "R3 branch mid group");
    drive(4, '{4,0,4,0,0,0,0,0}, 1, "R4 second branch closes");
    drive(3, '{4,4,4,0,0,0,0,0}, 1, "R2 two branch slots");
    drive(3, '{2,0,0,0,0,0,0,0}, 1, "R5 two-slot first");
    drive(2, '{0,2,0,0,0,0,0,0}, 1, "R5 two-slot not first");
    drive(2, '{4,2,0,0,0,0,0,0}, 1, "R5 two-slot after branch");
    drive(3, '{3,0,4,0,0,0,0,0}, 1, "R6 micro then simple");
    drive(3, '{3,4,4,0,0,0,0,0}, 1, "R6 micro with branches");
    drive(5, '{1,0,0,0,0,0,0,0}, 1, "R7 cr first");
    drive(2, '{0,1,0,0,0,0,0,0}, 1, "R7 cr second");
    drive(3, '{4,1,0,0,0,0,0,0}, 1, "R7 cr after branch");
    drive(4, '{5,6,7,0,0,0,0,0}, 1, "R11 codes 5-7 simple");
    drive(15, '{4,0,0,0,0,4,0,0}, 1, "R11 count clamp");
    drive(2, '{0,0,0,0,0,0,0,0}, 0, "R9 stall hold");
    drive(7, '{3,0,0,0,0,0,0,0}, 0, "R9 stall hold again");
    drive(2, '{0,0,0,0,0,0,0,0}, 1, "R9 resume");
    for (int t = 0; t < 3000; t++) begin
      int cl[8];
      for (int k = 0; k < 8; k++)
        cl[k] = ($urandom_range(0, 3) == 0) ? 4 : int'($urandom_range(0, 7));
      drive(int'($urandom_range(0, 10)), cl, ($urandom_range(0, 3) != 0),
            "R8 random mix");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule